// File: doc/BRIEF.md
# Leveled Interrupt Controller with Vectoring

This block gathers up to 63 active-high interrupt lines per controller unit. A unit may be instantiated once or twice. Each source carries a programmable level from 1 to 7 and a mask bit. Every unit converts its enabled, pending sources into a one-hot-per-level 7-bit vector. The vectors of all units are ORed together, and the highest level present is registered as a 3-bit request for the processor.

When the processor takes the interrupt, it performs a byte read on the acknowledge port. The address carries the unit in bit 8 and the level in bits [4:2]. In the cycle after the read, the block returns an 8-bit vector number for the winning source at that level, or the spurious vector 24 if no source at that level is pending. The acknowledge never touches the sources. Software must mask a source, or the source must drop its line, before the request goes away.

Levels and masks are set through a simple write port. The address map inside a unit's 256-byte window is as follows:
- 0x00 holds the upper mask half, where bit i covers source 32+i.
- 0x04 holds the lower mask half, where bit i covers source i.
- 0x40+n holds the level of source n, taken from data[2:0].

In the write address, bit 8 selects the unit.

Top module: `irqv_hub`

## Requirements
- R1: After reset every source is masked and at level 0, `irq_level_o` is 0, `ack_valid_o` is 0, and asserted sources produce no request until they are configured.
- R2: `lvl_dec_o` bit n-1 is set exactly when some unmasked, asserted source in any unit is programmed to level n (1..7).
- R3: `irq_level_o` equals the highest set level of `lvl_dec_o` one clock edge earlier, and is 0 when none is set.
- R4: Requests from both units are merged, so a source in unit 1 can supply the highest level.
- R5: An acknowledge with `ack_req_i` high returns, one edge later with `ack_valid_o` high, the value base+n on `ack_vec_o`. Here n is the winning source, the level comes from `ack_addr_i[4:2]`, and the unit comes from `ack_addr_i[8]`. Unit 0 has base 64 and unit 1 has base 128.
- R6: Among pending sources at the acknowledged level, the lowest-numbered source wins.
- R7: When no enabled source is pending at the acknowledged level, `ack_vec_o` is 24.
- R8: An acknowledge does not change the pending state: `irq_level_o` keeps its value afterwards.
- R9: Source line 0 of each unit is never a request, and writes to its level address (0x40) have no effect.
- R10: A source programmed to level 0 never contributes a request, even when unmasked and asserted.
- R11: Writing the mask register at offset 0x04 leaves the mask register at offset 0x00 unchanged, and the reverse also holds.
- R12: A mask bit of 1 blocks its source from both the level output and the acknowledge choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 128 | Source lines, unit u at bits [64u+63:64u], bit 0 of each unit unused |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 9 | Write address: bit 8 unit, bits [7:0] offset |
| wr_data_i | input | 32 | Write data |
| ack_req_i | input | 1 | Acknowledge byte read strobe |
| ack_addr_i | input | 9 | Acknowledge address: bit 8 unit, bits [4:2] level |
| lvl_dec_o | output | 7 | Merged decoded level vector, bit n-1 for level n |
| irq_level_o | output | 3 | Registered highest pending level, 0 for none |
| ack_valid_o | output | 1 | Acknowledge data valid |
| ack_vec_o | output | 8 | Returned vector number |

## Verification
The level encoder is exercised in several ways: one source alone, two sources at different levels in one unit, sources split across both units, and a high-level source in the upper mask half next to a lower one. Together these separate the highest-level choice from a plain OR and from a unit-0-only view. Lines at level 0 and on source 0 show whether unconfigured inputs leak into the request. For acknowledges, two sources at the same level expose the priority order. An empty level exposes the spurious path, and masking the winner checks that the choice follows the mask. Acks to each unit tell the two vector bases apart.

// File: rtl/irqv_pkg.sv
// Shared constants and helpers for the leveled interrupt controller.
// Assumes 64 source slots per unit, slot 0 unused.
package irqv_pkg;
    localparam int SRC_N   = 64;
    localparam int LVL_W   = 3;
    localparam int LVL_N   = 7;
    localparam int MASK_W  = 32;
    localparam logic [7:0] VEC_SPURIOUS = 8'd24;

    localparam logic [7:0] OFS_MASK_HI = 8'h00;
    localparam logic [7:0] OFS_MASK_LO = 8'h04;
    localparam logic [1:0] OFS_LVL_PG  = 2'b01;

    typedef logic [SRC_N-1:0][LVL_W-1:0] lvl_arr_t;

    // Encode the highest set bit of a decoded level vector into a level number.
    function automatic logic [LVL_W-1:0] top_level(input logic [LVL_N-1:0] dec);
        logic [LVL_W-1:0] r;
        r = '0;
        for (int i = 0; i < LVL_N; i++) begin
            if (dec[i]) r = LVL_W'(i + 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/irqv_regs.sv
// Per-unit configuration storage: two 32-bit mask halves and a 3-bit level
// per source. Assumes the caller has already qualified wr_en with the unit select.
module irqv_regs
    import irqv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_ofs,
    input  logic [31:0]      wr_data,
    output logic [SRC_N-1:0] mask_o,
    output lvl_arr_t         lvl_o
);
    localparam int HALVES = SRC_N / MASK_W;

    logic [MASK_W-1:0] mask_half_q [HALVES];

    // Each mask half is its own register with its own write offset.
    for (genvar h = 0; h < HALVES; h++) begin : g_mask
        localparam logic [7:0] OFS = (h == 0) ? OFS_MASK_LO : OFS_MASK_HI;
        // Purpose: hold one mask half, reset to all masked.
        always_ff @(posedge clk) begin
            if (!rst_n)                         mask_half_q[h] <= '1;
            else if (wr_en && wr_ofs == OFS)    mask_half_q[h] <= wr_data;
        end
        assign mask_o[h*MASK_W +: MASK_W] = mask_half_q[h];
    end

    assign lvl_o[0] = '0;
    // Level registers for sources 1..63; slot 0 is never stored.
    for (genvar n = 1; n < SRC_N; n++) begin : g_lvl
        // Purpose: hold the programmed level of source n, reset to 0.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_o[n] <= '0;
            else if (wr_en && wr_ofs[7:6] == OFS_LVL_PG && wr_ofs[5:0] == 6'(n))
                lvl_o[n] <= wr_data[LVL_W-1:0];
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^wr_data[31:LVL_W] ^ ^wr_data[LVL_W-1:0];
endmodule

// File: rtl/irqv_unit.sv
// One controller unit: combinational level decode and acknowledge choice.
// Assumes src/mask/lvl slot 0 carry no meaning; lowest source number wins a level.
module irqv_unit
    import irqv_pkg::*;
#(
    parameter logic [7:0] BASE = 8'd64
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_ofs,
    input  logic [31:0]      wr_data,
    input  logic [SRC_N-1:0] src,
    input  logic [LVL_W-1:0] ack_lvl,
    output logic [LVL_N-1:0] dec_o,
    output logic [7:0]       ack_vec_o
);
    logic [SRC_N-1:0] mask;
    lvl_arr_t         lvl;
    logic [SRC_N-1:0] active;

    irqv_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ofs  (wr_ofs),
        .wr_data (wr_data),
        .mask_o  (mask),
        .lvl_o   (lvl)
    );

    assign active[0] = 1'b0;
    for (genvar n = 1; n < SRC_N; n++) begin : g_act
        assign active[n] = src[n] && !mask[n] && (lvl[n] != '0);
    end

    // Purpose: map each active source onto its level bit.
    always_comb begin
        dec_o = '0;
        for (int n = 1; n < SRC_N; n++) begin
            if (active[n]) dec_o[lvl[n] - 1'b1] = 1'b1;
        end
    end

    // Purpose: pick the lowest-numbered active source at the acknowledged level.
    always_comb begin
        logic       hit;
        logic [5:0] idx;
        hit = 1'b0;
        idx = '0;
        for (int n = SRC_N - 1; n >= 1; n--) begin
            if (active[n] && lvl[n] == ack_lvl) begin
                hit = 1'b1;
                idx = 6'(n);
            end
        end
        ack_vec_o = hit ? BASE + {2'b00, idx} : VEC_SPURIOUS;
    end

    logic unused_slot0;
    assign unused_slot0 = src[0] ^ mask[0];
endmodule

// File: rtl/irqv_combiner.sv
// Merges the decoded level vectors of all units and registers the highest level.
// Assumes NUM >= 1.
module irqv_combiner
    import irqv_pkg::*;
#(
    parameter int NUM = 2
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM-1:0][LVL_N-1:0] dec_i,
    output logic [LVL_N-1:0]          dec_all_o,
    output logic [LVL_W-1:0]          level_o
);
    // Purpose: OR the per-unit level vectors.
    always_comb begin
        dec_all_o = '0;
        for (int u = 0; u < NUM; u++) dec_all_o |= dec_i[u];
    end

    // Purpose: register the encoded highest pending level.
    always_ff @(posedge clk) begin
        if (!rst_n) level_o <= '0;
        else        level_o <= top_level(dec_all_o);
    end
endmodule

// File: rtl/irqv_hub.sv
// Top: NUM_UNITS controller units, the level combiner and the registered
// acknowledge return path. Assumes NUM_UNITS is 1 or 2; unit u has base
// BASE_FIRST + u*BASE_STEP, which must stay below 256-63.
module irqv_hub
    import irqv_pkg::*;
#(
    parameter int NUM_UNITS  = 2,
    parameter int BASE_FIRST = 64,
    parameter int BASE_STEP  = 64
)(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_UNITS*64-1:0]           src_i,
    input  logic                              wr_en_i,
    input  logic [8+((NUM_UNITS>1)?$clog2(NUM_UNITS):1)-1:0] wr_addr_i,
    input  logic [31:0]                       wr_data_i,
    input  logic                              ack_req_i,
    input  logic [8+((NUM_UNITS>1)?$clog2(NUM_UNITS):1)-1:0] ack_addr_i,
    output logic [6:0]                        lvl_dec_o,
    output logic [2:0]                        irq_level_o,
    output logic                              ack_valid_o,
    output logic [7:0]                        ack_vec_o
);
    localparam int UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;

    logic [NUM_UNITS-1:0][LVL_N-1:0] dec_u;
    logic [7:0]                      vec_u [NUM_UNITS];
    logic [LVL_W-1:0]                ack_lvl;
    logic [UNIT_W-1:0]               ack_unit;
    logic [UNIT_W-1:0]               wr_unit;

    assign ack_lvl  = ack_addr_i[4:2];
    assign ack_unit = ack_addr_i[8 +: UNIT_W];
    assign wr_unit  = wr_addr_i[8 +: UNIT_W];

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        localparam logic [7:0] BASE = 8'(BASE_FIRST + u * BASE_STEP);
        irqv_unit #(.BASE(BASE)) u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en_i && wr_unit == UNIT_W'(u)),
            .wr_ofs    (wr_addr_i[7:0]),
            .wr_data   (wr_data_i),
            .src       (src_i[u*SRC_N +: SRC_N]),
            .ack_lvl   (ack_lvl),
            .dec_o     (dec_u[u]),
            .ack_vec_o (vec_u[u])
        );
    end

    irqv_combiner #(.NUM(NUM_UNITS)) u_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_i     (dec_u),
        .dec_all_o (lvl_dec_o),
        .level_o   (irq_level_o)
    );

    // Purpose: select the addressed unit's vector, spurious for an absent unit.
    logic [7:0] ack_sel;
    always_comb begin
        ack_sel = VEC_SPURIOUS;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (ack_unit == UNIT_W'(u)) ack_sel = vec_u[u];
        end
    end

    // Purpose: register the acknowledge result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid_o <= 1'b0;
            ack_vec_o   <= '0;
        end else begin
            ack_valid_o <= ack_req_i;
            if (ack_req_i) ack_vec_o <= ack_sel;
        end
    end

    logic unused_ack_addr;
    assign unused_ack_addr = ^ack_addr_i[7:5] ^ ^ack_addr_i[1:0];
endmodule

// File: rtl/irqv_hub_chk.sv
// Assertion checker for irqv_hub, attached by bind below.
module irqv_hub_chk (
    input logic         clk,
    input logic         rst_n,
    input logic [127:0] src_i,
    input logic         ack_req_i,
    input logic [6:0]   lvl_dec_o,
    input logic [2:0]   irq_level_o,
    input logic         ack_valid_o,
    input logic [7:0]   ack_vec_o
);
    // R2
    no_src_no_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == '0) |-> (lvl_dec_o == '0));
    // R3
    empty_gives_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_dec_o == '0) |=> (irq_level_o == 3'd0));
    // R3
    top_level_seven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_dec_o[6] |=> (irq_level_o == 3'd7));
    // R5
    ack_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req_i |=> ack_valid_o);
    // R7
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_o |-> (ack_vec_o == 8'd24 || (ack_vec_o > 8'd64 && ack_vec_o < 8'd192)));
endmodule

bind irqv_hub irqv_hub_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src_i),
    .ack_req_i   (ack_req_i),
    .lvl_dec_o   (lvl_dec_o),
    .irq_level_o (irq_level_o),
    .ack_valid_o (ack_valid_o),
    .ack_vec_o   (ack_vec_o)
);

// File: tb/tb_irqv_hub.sv
module tb_irqv_hub;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] src_i = '0;
    logic         wr_en_i = 1'b0;
    logic [8:0]   wr_addr_i = '0;
    logic [31:0]  wr_data_i = '0;
    logic         ack_req_i = 1'b0;
    logic [8:0]   ack_addr_i = '0;
    logic [6:0]   lvl_dec_o;
    logic [2:0]   irq_level_o;
    logic         ack_valid_o;
    logic [7:0]   ack_vec_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irqv_hub dut (.*);

    // Entries: {unit0 sources, unit1 sources, expected decoded vector, expected level}
    localparam int NT = 9;
    localparam logic [137:0] TBL [NT] = '{
        {64'h0,                  64'h0,                  7'b0000000, 3'd0},
        {64'h2,                  64'h0,                  7'b0000100, 3'd3},
        {64'h22,                 64'h0,                  7'b0010100, 3'd5},
        {64'h2_0000_0000,        64'h0,                  7'b0000010, 3'd2},
        {64'h100_0000_0002,      64'h0,                  7'b1000100, 3'd7},
        {64'h0,                  64'h80,                 7'b0001000, 3'd4},
        {64'h20,                 64'h8000_0000_0000_0000,7'b0110000, 3'd6},
        {64'h400,                64'h0,                  7'b0000000, 3'd0},
        {64'h1,                  64'h1,                  7'b0000000, 3'd0}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic u, input logic [7:0] ofs, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = {u, ofs}; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic ack(input logic u, input logic [2:0] lv, input logic [7:0] exp, input string tag);
        @(negedge clk);
        ack_req_i = 1'b1; ack_addr_i = {u, 3'b000, lv, 2'b00};
        @(negedge clk);
        ack_req_i = 1'b0;
        chk(32'(ack_valid_o), 32'd1, tag);
        chk(32'(ack_vec_o), 32'(exp), tag);
    endtask

    task automatic settle_src(input logic [63:0] s0, input logic [63:0] s1);
        @(negedge clk);
        src_i = {s1, s0};
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        src_i = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: all masked at reset, sources asserted
        chk(32'(irq_level_o), 0, "R1 level");
        chk(32'(lvl_dec_o), 0, "R1 dec");
        chk(32'(ack_valid_o), 0, "R1 ack_valid");

        // configure unit 0
        wr(1'b0, 8'h41, 32'd3);
        wr(1'b0, 8'h42, 32'd3);
        wr(1'b0, 8'h45, 32'd5);
        wr(1'b0, 8'h61, 32'd2);   // source 33
        wr(1'b0, 8'h68, 32'd7);   // source 40
        wr(1'b0, 8'h40, 32'd6);   // R9: slot 0 write ignored
        wr(1'b0, 8'h4A, 32'd0);   // R10: source 10 stays level 0
        // configure unit 1
        wr(1'b1, 8'h47, 32'd4);
        wr(1'b1, 8'h7F, 32'd6);
        // still masked: R1/R12
        chk(32'(irq_level_o), 0, "R12 masked level");
        wr(1'b0, 8'h04, 32'h0);
        wr(1'b0, 8'h00, 32'h0);
        wr(1'b1, 8'h04, 32'h0);
        wr(1'b1, 8'h00, 32'h0);

        // table walk: R2 R3 R4 R9 R10
        for (int i = 0; i < NT; i++) begin
            @(negedge clk);
            src_i = {TBL[i][73:10], TBL[i][137:74]};
            #1;
            chk(32'(lvl_dec_o), 32'(TBL[i][9:3]), $sformatf("R2 dec entry %0d", i));
            @(negedge clk);
            chk(32'(irq_level_o), 32'(TBL[i][2:0]), $sformatf("R3 R4 level entry %0d", i));
        end

        // R6 R5: two sources at level 3, lowest wins, base 64
        settle_src(64'h6, 64'h80);
        ack(1'b0, 3'd3, 8'd65, "R6 lowest wins");
        // R8: level unchanged after ack
        chk(32'(irq_level_o), 4, "R8 pending kept");
        // R5: unit 1 base 128
        ack(1'b1, 3'd4, 8'd135, "R5 unit1 vector");
        // R7: nothing at level 4 in unit 0
        ack(1'b0, 3'd4, 8'd24, "R7 spurious");
        // R10: source 10 at level 0 not chosen for level 0 ack
        settle_src(64'h400, 64'h0);
        ack(1'b0, 3'd0, 8'd24, "R10 level0 ack");
        // R12: mask source 1, source 2 wins
        wr(1'b0, 8'h04, 32'h2);
        settle_src(64'h6, 64'h0);
        ack(1'b0, 3'd3, 8'd66, "R12 masked skip");
        // R11: mask whole low half, high half untouched
        wr(1'b0, 8'h04, 32'hFFFF_FFFF);
        settle_src(64'h100_0000_0020, 64'h0);
        chk(32'(lvl_dec_o), 32'b1000000, "R11 high half kept");
        chk(32'(irq_level_o), 7, "R11 level");
        // R1: reset clears configuration
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(32'(irq_level_o), 0, "R1 after reset");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule